// File: doc/BRIEF.md
# Address-Masked GPIO with Per-Pin Interrupt Detection

This block is an eight-pin general-purpose I/O port behind a plain memory-mapped register bus with byte-wide data. Each pin has a direction bit. When the direction bit is set, the pin drives the value held in its output register. When it is clear, the pin is sampled through a two-flop synchronizer. Pin data is reached through a data window of 256 word addresses. In that window, byte-address bits [9:2] act as a per-pin mask, so one bus access can touch any chosen subset of pins and leave the rest alone.

Each pin also has its own interrupt detector, configured by three control bits: sense (level or edge), both-edges, and event polarity. Raw status, enable, masked status and a write-one-to-clear register sit at fixed offsets. The OR of the masked status bits drives a single interrupt line. The detector works in one of five modes: level-low, level-high, falling edge, rising edge, or either edge. In a level mode, raw status follows the synchronized pin and the sticky edge latch is held at zero. In an edge mode, the latch sets on a matching edge and holds until software clears it.

Bus accesses complete in one cycle. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational and valid in the same cycle as `bus_sel` with `bus_wr` low. At all other times it is zero.

Top module: `gpio_masked`

## Requirements
- R1: After reset every control register, the output register and every edge latch are zero: `pin_oe` is 0x00, `irq` is 0, and all register reads return 0x00.
- R2: The direction register is at byte offset 0x400. Bit n set makes pin n an output, and `pin_oe` equals the register value. The register reads back at 0x400.
- R3: A write with byte address bits [11:10] equal to 0 is a data-window write. The write updates `pin_out[n]` only when address bit n+2 is set and pin n is an output. Pins that are inputs or unmasked keep their output value.
- R4: A data-window read returns, at each masked position n (address bit n+2 set), the driven value for an output pin or the synchronized input for an input pin. It returns zero at every unmasked position.
- R5: Pin inputs pass through two flops. A change on `pin_in` becomes visible to a read after the second rising clock edge, and not after the first.
- R6: Sense register at 0x404 and event register at 0x40C: with sense bit 1, raw status is the synchronized pin when the event bit is 1 (level-high) and its inverse when the event bit is 0 (level-low). A clear write does not hold it low.
- R7: With sense bit 0 and both-edges bit 0, an edge in the event direction sets a sticky raw bit: rising when the event bit is 1, falling when it is 0. The opposite edge neither sets nor clears it.
- R8: Both-edges register at 0x408: for an edge-sense pin with this bit set, both rising and falling edges set the raw bit, regardless of the event bit.
- R9: Writing 1 to bit n of the clear register at 0x41C clears pin n's edge latch. Writing 0 to a bit leaves that bit unchanged.
- R10: Masked status at 0x418 equals raw status (0x414) AND the enable register (0x410). `irq` is 1 exactly when some masked bit is 1.
- R11: Reads of 0x41C and of unmapped offsets (for example 0x420) return 0x00. Writes to 0x414 and 0x418 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when no read is selected |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Output register value per pin |
| pin_oe | output | 8 | Output enable per pin (direction register) |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are stable across each rising clock edge, and that every access lasts exactly one cycle. The stimulus meets this by changing bus and pin inputs only on falling clock edges. It deasserts `bus_sel` after each access. It changes `pin_in` only in steps that flip the specific bits a test targets. After each change it waits at least four cycles, so the synchronizer and the edge latch have settled before status is sampled.

// File: rtl/gpio_masked_pkg.sv
package gpio_masked_pkg;

    localparam int NPINS  = 8;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_EVT   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_IE    = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;

    typedef enum logic [2:0] {
        DET_LVL_LO,
        DET_LVL_HI,
        DET_EDGE_FALL,
        DET_EDGE_RISE,
        DET_EDGE_ANY
    } det_mode_e;

endpackage

// File: rtl/gpio_masked_sync.sv
module gpio_masked_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_masked_pin_irq.sv
module gpio_masked_pin_irq
    import gpio_masked_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sense,
    input  logic both,
    input  logic evt,
    input  logic smp,
    input  logic smp_prev,
    input  logic clr,
    output logic raw
);
    det_mode_e mode;
    logic      lvl_val;
    logic      hit;
    logic      is_level;
    logic      latch_q;
    logic      rise;
    logic      fall;

    assign rise = smp & ~smp_prev;
    assign fall = ~smp & smp_prev;

    // mode decode: sense takes priority over both-edges
    always_comb begin
        if (sense)     mode = evt ? DET_LVL_HI : DET_LVL_LO;
        else if (both) mode = DET_EDGE_ANY;
        else           mode = evt ? DET_EDGE_RISE : DET_EDGE_FALL;
    end

    always_comb begin
        lvl_val  = 1'b0;
        hit      = 1'b0;
        is_level = 1'b0;
        unique case (mode)
            DET_LVL_LO:    begin is_level = 1'b1; lvl_val = ~smp; end
            DET_LVL_HI:    begin is_level = 1'b1; lvl_val = smp;  end
            DET_EDGE_FALL: hit = fall;
            DET_EDGE_RISE: hit = rise;
            DET_EDGE_ANY:  hit = rise | fall;
            default:       hit = 1'b0;
        endcase
    end

    // sticky edge latch; a new edge wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= 1'b0;
        else if (is_level) latch_q <= 1'b0;
        else if (hit)      latch_q <= 1'b1;
        else if (clr)      latch_q <= 1'b0;
    end

    assign raw = is_level ? lvl_val : latch_q;
endmodule

// File: rtl/gpio_masked_regs.sv
module gpio_masked_regs
    import gpio_masked_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_smp,
    input  logic [NPINS-1:0]  raw,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  evt_q,
    output logic [NPINS-1:0]  ie_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  clr_pulse
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + NPINS - 1;

    logic              wr_en;
    logic              rd_en;
    logic              in_window;
    logic [NPINS-1:0]  pin_mask;
    logic [NPINS-1:0]  pin_view;
    logic [NPINS-1:0]  rd_mux;

    assign wr_en     = bus_sel & bus_wr;
    assign rd_en     = bus_sel & ~bus_wr;
    assign in_window = (bus_addr[ADDR_W-1:MASK_HI+1] == '0);
    assign pin_mask  = bus_addr[MASK_HI:MASK_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            evt_q   <= '0;
            ie_q    <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFS_DIR:   dir_q   <= bus_wdata;
                OFS_SENSE: sense_q <= bus_wdata;
                OFS_BOTH:  both_q  <= bus_wdata;
                OFS_EVT:   evt_q   <= bus_wdata;
                OFS_IE:    ie_q    <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // data window: only masked output pins take the written value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en && in_window) begin
            out_q <= (out_q & ~(pin_mask & dir_q)) | (bus_wdata & pin_mask & dir_q);
        end
    end

    assign clr_pulse = (wr_en && bus_addr == OFS_CLR) ? bus_wdata : '0;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_view
            assign pin_view[g] = dir_q[g] ? out_q[g] : pin_smp[g];
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (in_window) begin
            rd_mux = pin_view & pin_mask;
        end else begin
            unique case (bus_addr)
                OFS_DIR:   rd_mux = dir_q;
                OFS_SENSE: rd_mux = sense_q;
                OFS_BOTH:  rd_mux = both_q;
                OFS_EVT:   rd_mux = evt_q;
                OFS_IE:    rd_mux = ie_q;
                OFS_RAW:   rd_mux = raw;
                OFS_MSK:   rd_mux = raw & ie_q;
                default:   rd_mux = '0;
            endcase
        end
    end

    assign bus_rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/gpio_masked.sv
module gpio_masked
    import gpio_masked_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] smp;
    logic [NPINS-1:0] smp_prev;
    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] sense_q;
    logic [NPINS-1:0] both_q;
    logic [NPINS-1:0] evt_q;
    logic [NPINS-1:0] ie_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] clr_pulse;

    gpio_masked_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (smp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_prev <= '0;
        else        smp_prev <= smp;
    end

    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pin
            gpio_masked_pin_irq u_det (
                .clk      (clk),
                .rst_n    (rst_n),
                .sense    (sense_q[p]),
                .both     (both_q[p]),
                .evt      (evt_q[p]),
                .smp      (smp[p]),
                .smp_prev (smp_prev[p]),
                .clr      (clr_pulse[p]),
                .raw      (raw[p])
            );
        end
    endgenerate

    gpio_masked_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_smp   (smp),
        .raw       (raw),
        .dir_q     (dir_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .evt_q     (evt_q),
        .ie_q      (ie_q),
        .out_q     (out_q),
        .clr_pulse (clr_pulse)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(raw & ie_q);
endmodule

// File: rtl/gpio_masked_chk.sv
module gpio_masked_chk
    import gpio_masked_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  ie_q,
    input logic              irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(pin_out));

    // R3
    input_pin_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

    // R11
    clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_CLR) |-> (bus_rdata == '0));

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_q != '0));
endmodule

bind gpio_masked gpio_masked_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .ie_q      (ie_q),
    .irq       (irq)
);

// File: tb/tb_gpio_masked.sv
module tb_gpio_masked;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_masked dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {address, write data, expected pin_out}, direction preset to 0xF0
    localparam logic [27:0] VEC [4] = '{
        {12'h040, 8'hFF, 8'h10},
        {12'h3FC, 8'hA5, 8'hA0},
        {12'h200, 8'h00, 8'h20},
        {12'h0FC, 8'hFF, 8'h30}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        bus_read(12'h400, r); check("R1 dir", r, 8'h00);
        bus_read(12'h410, r); check("R1 ie", r, 8'h00);

        // R2 direction
        bus_write(12'h400, 8'hF0);
        bus_read(12'h400, r); check("R2 dir readback", r, 8'hF0);
        check("R2 pin_oe", pin_oe, 8'hF0);

        // R3 / R4 vector table
        for (int i = 0; i < 4; i++) begin
            bus_write(VEC[i][27:16], VEC[i][15:8]);
            check("R3 pin_out", pin_out, VEC[i][7:0]);
            bus_read(12'h3FC, r);
            check("R4 full read", r, VEC[i][7:0]);
        end

        // R5 two-flop latency
        @(negedge clk);
        pin_in = 8'h0F;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3FC;
        #1 check("R5 after one edge", bus_rdata, 8'h30);
        bus_sel = 1'b0;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3FC;
        #1 check("R5 after two edges", bus_rdata, 8'h3F);
        bus_sel = 1'b0;

        // R4 masked read
        bus_read(12'h00C, r); check("R4 mask 0x03", r, 8'h03);
        bus_read(12'h180, r); check("R4 mask 0x60", r, 8'h20);

        // R6 level-high on pin 0
        bus_write(12'h40C, 8'h01);
        bus_write(12'h404, 8'h01);
        bus_write(12'h410, 8'h01);
        bus_read(12'h414, r); check("R6 level high raw", r, 8'h01);
        check("R10 irq level", {7'd0, irq}, 8'h01);
        bus_write(12'h41C, 8'h01);
        bus_read(12'h414, r); check("R6 level not held by clear", r, 8'h01);
        set_pins(8'h0E);
        bus_read(12'h414, r); check("R6 level released", r, 8'h00);
        check("R10 irq off", {7'd0, irq}, 8'h00);
        bus_write(12'h40C, 8'h00);
        bus_read(12'h414, r); check("R6 level low raw", r, 8'h01);
        bus_write(12'h404, 8'h00);
        bus_read(12'h414, r); check("R6 back to edge", r, 8'h00);

        // R7 rising edge on pin 1
        bus_write(12'h40C, 8'h02);
        bus_write(12'h410, 8'h02);
        set_pins(8'h0C);
        bus_read(12'h414, r); check("R7 opposite edge ignored", r, 8'h00);
        set_pins(8'h0E);
        bus_read(12'h414, r); check("R7 rise latched", r, 8'h02);
        check("R10 irq edge", {7'd0, irq}, 8'h01);
        set_pins(8'h0C);
        bus_read(12'h414, r); check("R7 sticky", r, 8'h02);
        bus_write(12'h41C, 8'h00);
        bus_read(12'h414, r); check("R9 zero write no effect", r, 8'h02);
        bus_write(12'h41C, 8'h02);
        bus_read(12'h414, r); check("R9 clear", r, 8'h00);
        check("R9 irq cleared", {7'd0, irq}, 8'h00);

        // R7 falling edge on pin 2, R10 masking
        set_pins(8'h08);
        bus_read(12'h414, r); check("R7 fall latched", r, 8'h04);
        bus_read(12'h418, r); check("R10 masked off", r, 8'h00);
        check("R10 irq masked", {7'd0, irq}, 8'h00);
        bus_write(12'h410, 8'h04);
        bus_read(12'h418, r); check("R10 masked on", r, 8'h04);
        check("R10 irq on", {7'd0, irq}, 8'h01);
        bus_write(12'h41C, 8'h04);

        // R8 both edges on pin 3
        bus_write(12'h408, 8'h08);
        bus_write(12'h410, 8'h08);
        set_pins(8'h00);
        bus_read(12'h414, r); check("R8 fall", r, 8'h08);
        bus_write(12'h41C, 8'h08);
        bus_read(12'h414, r); check("R8 cleared", r, 8'h00);
        set_pins(8'h08);
        bus_read(12'h414, r); check("R8 rise", r, 8'h08);

        // R11 read-only status and zero reads
        bus_write(12'h414, 8'hFF);
        bus_write(12'h418, 8'hFF);
        bus_read(12'h414, r); check("R11 raw write ignored", r, 8'h08);
        bus_read(12'h410, r); check("R11 ie untouched", r, 8'h08);
        bus_read(12'h41C, r); check("R11 clear reads zero", r, 8'h00);
        bus_read(12'h420, r); check("R11 unmapped zero", r, 8'h00);
        check("R2 pin_oe final", pin_oe, 8'hF0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule